// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the control half of a boundary-scan port. It follows the test clock and the mode-select line through the sixteen states of the standard test-port state machine. It holds an 8-bit instruction register, built as a shift stage and a shadow stage, and a 1-bit bypass register. The serial output and its enable are registered on the falling test-clock edge, so together they act as a three-state pin.

The current instruction is decoded into three things: the data register chosen for scanning, the device mode, and two run strobes. The strobes mark the idle state while a run-test or toggle-outputs instruction is loaded. Capture, shift and update strobes go to data registers outside the block. The boundary and control registers return their serial outputs on two inputs.

The instruction scan always captures the fixed status 8'b10000001. Reset loads all ones into the shadow stage. Bit 7 of an opcode carries no meaning, and any opcode that is not defined falls back to bypass.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The state register uses these codes: reset=0, idle=1, dr-select=2, dr-capture=3, dr-shift=4, dr-exit1=5, dr-pause=6, dr-exit2=7, dr-update=8, ir-select=9, ir-capture=10, ir-shift=11, ir-exit1=12, ir-pause=13, ir-exit2=14, ir-update=15. It moves on the `tms` level sampled at each rising `tck` edge and is 0 while `por_n` is low.
- R2: Five rising edges with `tms` high bring the controller to state 0 from any state.
- R3: On the rising edge that leaves ir-capture, the instruction shift stage loads 8'b10000001. An instruction scan returns this value least significant bit first: 1,0,0,0,0,0,0,1.
- R4: The instruction shift stage moves toward `tdo` and takes `tdi` into bit 7. It shifts on every rising edge taken in ir-shift, including the edge that leaves that state, and not on the edge that enters it. Bits 6:0 pass to the shadow on the falling edge in ir-update, so the decoded outputs still show the old instruction just after the rising edge into ir-update.
- R5: While `por_n` is low, and on every falling edge in state 0, the shadow holds all ones. This decodes as bypass and normal mode.
- R6: The decode ignores opcode bit 7. `sel_dr` is 00 for bypass, 01 for boundary and 10 for control. `dev_mode` is 00 for normal, 01 for test and 10 for outputs at high impedance. The opcodes decode as follows, as {sel,mode}: 0x00 and 0x03 give {01,01}; 0x02 gives {01,00}; 0x06 gives {00,10}; 0x07 gives {00,01}; 0x09 gives {00,01}; 0x0A gives {01,00}; 0x0B gives {01,01}; 0x0C gives {01,00}; 0x0D gives {00,01}; 0x0E gives {10,00}; 0x0F gives {10,01}.
- R7: Every other value of bits 6:0 decodes as bypass in normal mode.
- R8: The bypass bit loads 0 on the edge that leaves dr-capture and takes `tdi` on each shift edge. In dr-shift, `tdo` carries the bypass bit, `bsr_so` or `bcr_so`, chosen by `sel_dr`.
- R9: On each falling edge, `tdo_en` is set to 1 if the state is dr-shift or ir-shift and to 0 otherwise. In the same edge `tdo` takes the least significant bit of the register being scanned.
- R10: `capture_dr`, `shift_dr` and `update_dr` are each high exactly while the state is dr-capture, dr-shift or dr-update.
- R11: `run_bcr` is high only in idle with opcode 0x09 loaded. `run_toggle` is high only in idle with opcode 0x0D loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial out of external boundary register |
| bcr_so | input | 1 | Serial out of external control register |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Drive enable for tdo |
| tap_state | output | 4 | Current state code |
| sel_dr | output | 2 | Selected data register |
| dev_mode | output | 2 | Device mode |
| capture_dr | output | 1 | Data register capture strobe |
| shift_dr | output | 1 | Data register shift strobe |
| update_dr | output | 1 | Data register update strobe |
| run_bcr | output | 1 | Run-test operation active |
| run_toggle | output | 1 | Output toggle operation active |

## Verification
State codes and the data-register strobes change on the rising edge that takes the matching `tms` value, and the bench reads them one time unit after that edge. `tdo` and `tdo_en` change on the following falling edge. The driver queues one expected item per clock, and the monitor compares it a quarter period after that falling edge. A newly loaded instruction is first seen in `sel_dr` and `dev_mode` after the falling edge in ir-update. The bench therefore checks the old decode right after entering ir-update and the new decode after the next rising edge.

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl #(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] IR_STATUS = 8'b1000_0001
) (
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  input  logic       tdi,
  input  logic       bsr_so,
  input  logic       bcr_so,
  output logic       tdo,
  output logic       tdo_en,
  output logic [3:0] tap_state,
  output logic [1:0] sel_dr,
  output logic [1:0] dev_mode,
  output logic       capture_dr,
  output logic       shift_dr,
  output logic       update_dr,
  output logic       run_bcr,
  output logic       run_toggle
);
  localparam int OP_W = IR_W - 1;
  localparam logic [3:0] S_TLR = 4'd0,  S_RTI = 4'd1,  S_SDR = 4'd2,  S_CDR = 4'd3,
                         S_SHD = 4'd4,  S_E1D = 4'd5,  S_PD  = 4'd6,  S_E2D = 4'd7,
                         S_UD  = 4'd8,  S_SIR = 4'd9,  S_CIR = 4'd10, S_SHI = 4'd11,
                         S_E1I = 4'd12, S_PI  = 4'd13, S_E2I = 4'd14, S_UI  = 4'd15;
  localparam logic [1:0] SEL_BYP = 2'b00, SEL_BSR = 2'b01, SEL_BCR = 2'b10;
  localparam logic [1:0] M_NORM = 2'b00, M_TEST = 2'b01, M_HIZ = 2'b10;

  logic [3:0]      state, nxt;
  logic [IR_W-1:0] ir_sh;
  logic [OP_W-1:0] ir_shadow;
  logic            bypass_r;

  always_comb begin
    case (state)
      S_TLR:   nxt = tms ? S_TLR : S_RTI;
      S_RTI:   nxt = tms ? S_SDR : S_RTI;
      S_SDR:   nxt = tms ? S_SIR : S_CDR;
      S_CDR:   nxt = tms ? S_E1D : S_SHD;
      S_SHD:   nxt = tms ? S_E1D : S_SHD;
      S_E1D:   nxt = tms ? S_UD  : S_PD;
      S_PD:    nxt = tms ? S_E2D : S_PD;
      S_E2D:   nxt = tms ? S_UD  : S_SHD;
      S_UD:    nxt = tms ? S_SDR : S_RTI;
      S_SIR:   nxt = tms ? S_TLR : S_CIR;
      S_CIR:   nxt = tms ? S_E1I : S_SHI;
      S_SHI:   nxt = tms ? S_E1I : S_SHI;
      S_E1I:   nxt = tms ? S_UI  : S_PI;
      S_PI:    nxt = tms ? S_E2I : S_PI;
      S_E2I:   nxt = tms ? S_UI  : S_SHI;
      default: nxt = tms ? S_SDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= S_TLR;
    else        state <= nxt;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)              ir_sh <= IR_STATUS;
    else if (state == S_CIR) ir_sh <= IR_STATUS;
    else if (state == S_SHI) ir_sh <= {tdi, ir_sh[IR_W-1:1]};

  always_ff @(negedge tck or negedge por_n)
    if (!por_n)              ir_shadow <= '1;
    else if (state == S_TLR) ir_shadow <= '1;
    else if (state == S_UI)  ir_shadow <= ir_sh[OP_W-1:0];

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)              bypass_r <= 1'b0;
    else if (state == S_CDR) bypass_r <= 1'b0;
    else if (state == S_SHD) bypass_r <= tdi;

  logic dr_bit;
  always_comb
    case (sel_dr)
      SEL_BSR: dr_bit = bsr_so;
      SEL_BCR: dr_bit = bcr_so;
      default: dr_bit = bypass_r;
    endcase

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo_en <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      tdo_en <= (state == S_SHD) || (state == S_SHI);
      tdo    <= (state == S_SHI) ? ir_sh[0] : dr_bit;
    end

  always_comb begin
    sel_dr   = SEL_BYP;
    dev_mode = M_NORM;
    case (ir_shadow)
      7'h00, 7'h03: begin sel_dr = SEL_BSR; dev_mode = M_TEST; end
      7'h02, 7'h0A, 7'h0C: sel_dr = SEL_BSR;
      7'h0B:        begin sel_dr = SEL_BSR; dev_mode = M_TEST; end
      7'h06:        dev_mode = M_HIZ;
      7'h07, 7'h09, 7'h0D: dev_mode = M_TEST;
      7'h0E:        sel_dr = SEL_BCR;
      7'h0F:        begin sel_dr = SEL_BCR; dev_mode = M_TEST; end
      default: ;
    endcase
  end

  assign tap_state  = state;
  assign capture_dr = (state == S_CDR);
  assign shift_dr   = (state == S_SHD);
  assign update_dr  = (state == S_UD);
  assign run_bcr    = (state == S_RTI) && (ir_shadow == 7'h09);
  assign run_toggle = (state == S_RTI) && (ir_shadow == 7'h0D);
endmodule

// File: rtl/scan_tap_ctrl_chk.sv
module scan_tap_ctrl_chk (
  input logic       tck,
  input logic       por_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [7:0] ir_sh,
  input logic       bypass_r,
  input logic       tdo_en,
  input logic [1:0] sel_dr,
  input logic [1:0] dev_mode,
  input logic       capture_dr,
  input logic       shift_dr,
  input logic       update_dr,
  input logic       run_bcr,
  input logic       run_toggle
);
  localparam logic [3:0] S_TLR = 4'd0, S_RTI = 4'd1, S_CDR = 4'd3, S_SHD = 4'd4,
                         S_E1D = 4'd5, S_CIR = 4'd10, S_SHI = 4'd11;

  a_r1_reset_hold: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR && tms) |=> state == S_TLR);
  a_r1_shift_exit: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_SHD && tms) |=> state == S_E1D);
  a_r3_status_load: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CIR) |=> ir_sh == 8'b1000_0001);
  a_r4_ir_shift: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_SHI) |=> ir_sh[6:0] == $past(ir_sh[7:1]));
  a_r5_reset_decode: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR && $past(state) == S_TLR) |-> (sel_dr == 2'b00 && dev_mode == 2'b00));
  a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CDR) |=> !bypass_r);
  a_r9_enable_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == S_SHD || state == S_SHI));
  a_r10_strobes: assert property (@(posedge tck) disable iff (!por_n)
    $onehot0({capture_dr, shift_dr, update_dr}));
  a_r11_run_mode: assert property (@(posedge tck) disable iff (!por_n)
    (run_bcr || run_toggle) |-> (state == S_RTI && dev_mode == 2'b01 && !(run_bcr && run_toggle)));
endmodule

bind scan_tap_ctrl scan_tap_ctrl_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .state(state), .ir_sh(ir_sh),
  .bypass_r(bypass_r), .tdo_en(tdo_en), .sel_dr(sel_dr), .dev_mode(dev_mode),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .run_bcr(run_bcr), .run_toggle(run_toggle));

// File: tb/test_scan_tap_ctrl.sv
module test_scan_tap_ctrl;
  localparam int PER = 20;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b1, bcr_so = 1'b0;
  logic tdo, tdo_en, capture_dr, shift_dr, update_dr, run_bcr, run_toggle;
  logic [3:0] tap_state;
  logic [1:0] sel_dr, dev_mode;

  scan_tap_ctrl i_scan_tap_ctrl (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so), .bcr_so(bcr_so),
    .tdo(tdo), .tdo_en(tdo_en), .tap_state(tap_state), .sel_dr(sel_dr),
    .dev_mode(dev_mode), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .run_bcr(run_bcr), .run_toggle(run_toggle));

  always #(PER/2) tck = ~tck;

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic q_en[$], q_bit[$];
  string q_tag[$];
  int n_cap = 0, n_sh = 0, n_upd = 0;
  logic [1:0] cur_mode = 2'b00;

  always @(posedge tck) begin
    if (capture_dr) n_cap++;
    if (shift_dr)   n_sh++;
    if (update_dr)  n_upd++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge tck);
    #(PER/4);
    if (q_en.size() > 0) begin
      logic e, b;
      string t;
      e = q_en.pop_front(); b = q_bit.pop_front(); t = q_tag.pop_front();
      chk({t, " tdo_en"}, int'(tdo_en), int'(e));
      if (e) chk({t, " tdo"}, int'(tdo), int'(b));
    end
  end

  task automatic tick(input logic m, input logic d, input logic xen, input logic xbit, input string tag);
    @(negedge tck);
    tms = m; tdi = d;
    q_en.push_back(xen); q_bit.push_back(xbit); q_tag.push_back(tag);
    @(posedge tck);
    #1;
  endtask

  function automatic logic [3:0] dec(input logic [7:0] op);
    case (op[6:0])
      7'h00, 7'h03: return 4'b0101;
      7'h02, 7'h0A, 7'h0C: return 4'b0100;
      7'h0B: return 4'b0101;
      7'h06: return 4'b0010;
      7'h07, 7'h09, 7'h0D: return 4'b0001;
      7'h0E: return 4'b1000;
      7'h0F: return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic load_ir(input logic [7:0] op);
    logic [7:0] st = 8'b1000_0001;
    logic [3:0] x = dec(op);
    tick(1, 0, 0, 0, "R9 idle");
    tick(1, 0, 0, 0, "R9 drsel");
    tick(0, 0, 0, 0, "R9 irsel");
    chk("R1 ir-capture code", tap_state, 10);
    tick(0, 0, 0, 0, "R9 ircap");
    for (int i = 0; i < 8; i++) tick(i == 7, op[i], 1, st[i], "R3 status out");
    tick(1, 0, 0, 0, "R9 exit1");
    chk("R1 ir-update code", tap_state, 15);
    chk("R4 mode before fall", dev_mode, cur_mode);
    tick(0, 0, 0, 0, "R9 update");
    chk($sformatf("R6/R7 sel op %02h", op), sel_dr, x[3:2]);
    chk($sformatf("R6/R7 mode op %02h", op), dev_mode, x[1:0]);
    cur_mode = x[1:0];
  endtask

  task automatic scan_dr(input logic [2:0] d, input logic [2:0] e, input string tag);
    int c0 = n_cap, s0 = n_sh, u0 = n_upd;
    tick(1, 0, 0, 0, "R9 idle");
    tick(0, 0, 0, 0, "R9 drsel");
    tick(0, 0, 0, 0, "R9 drcap");
    chk("R1 dr-shift code", tap_state, 4);
    for (int i = 0; i < 3; i++) tick(i == 2, d[i], 1, e[i], tag);
    tick(1, 0, 0, 0, "R9 dr exit1");
    chk("R1 dr-update code", tap_state, 8);
    tick(0, 0, 0, 0, "R9 drupd");
    chk("R10 capture count", n_cap - c0, 1);
    chk("R10 shift count", n_sh - s0, 3);
    chk("R10 update count", n_upd - u0, 1);
  endtask

  initial begin
    #(PER*4) done = 0;
    #(PER*1);
    chk("R1 reset state", tap_state, 0);
    chk("R9 reset tdo_en", tdo_en, 0);
    chk("R5 reset sel", sel_dr, 0);
    chk("R5 reset mode", dev_mode, 0);
    @(negedge tck) por_n = 1'b1;
    tick(1, 0, 0, 0, "R9 tlr");
    chk("R1 stays reset", tap_state, 0);
    tick(0, 0, 0, 0, "R9 tlr");
    chk("R1 idle code", tap_state, 1);

    // reference sequence: all ones in, then 101 through bypass
    load_ir(8'hFF);
    scan_dr(3'b101, 3'b010, "R8 bypass out");

    for (int op = 0; op < 18; op++) load_ir(8'(op));
    foreach (i_ops[k]) load_ir(i_ops[k]);

    load_ir(8'h03);
    scan_dr(3'b000, 3'b111, "R8 boundary out");
    load_ir(8'h0E);
    scan_dr(3'b111, 3'b000, "R8 control out");

    load_ir(8'h09);
    chk("R11 run_bcr idle", run_bcr, 1);
    chk("R11 run_toggle off", run_toggle, 0);
    tick(1, 0, 0, 0, "R9 idle");
    chk("R11 run_bcr off", run_bcr, 0);
    tick(0, 0, 0, 0, "R9 drsel");
    tick(1, 0, 0, 0, "R9 drcap");
    tick(1, 0, 0, 0, "R9 exit1");
    tick(0, 0, 0, 0, "R9 upd");
    load_ir(8'h8D);
    chk("R11 run_toggle idle", run_toggle, 1);
    chk("R11 run_bcr clear", run_bcr, 0);

    // R2 from dr-shift: first low phase is a shift of the bypass bit (0)
    tick(1, 0, 0, 0, "R9 idle");
    tick(0, 0, 0, 0, "R9 drsel");
    tick(0, 0, 0, 0, "R9 drcap");
    tick(1, 0, 1, 0, "R2 shift");
    tick(1, 0, 0, 0, "R2 walk");
    tick(1, 0, 0, 0, "R2 walk");
    tick(1, 0, 0, 0, "R2 walk");
    tick(1, 0, 0, 0, "R2 walk");
    chk("R2 from dr-shift", tap_state, 0);
    tick(1, 0, 0, 0, "R5 hold");
    chk("R5 sel after reset state", sel_dr, 0);
    chk("R5 mode after reset state", dev_mode, 0);
    cur_mode = 2'b00;

    // R2 from ir-pause
    tick(0, 0, 0, 0, "R9 tlr");
    tick(1, 0, 0, 0, "R9 idle");
    tick(1, 0, 0, 0, "R9 drsel");
    tick(0, 0, 0, 0, "R9 irsel");
    tick(1, 0, 0, 0, "R9 ircap");
    tick(0, 0, 0, 0, "R9 exit1");
    chk("R1 ir-pause code", tap_state, 13);
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 0, "R2 walk");
    chk("R2 from ir-pause", tap_state, 0);

    // R5: a test-mode instruction is cleared by reaching state 0
    tick(0, 0, 0, 0, "R9 tlr");
    load_ir(8'h00);
    chk("R5 test mode before", dev_mode, 1);
    for (int i = 0; i < 4; i++) tick(1, 0, 0, 0, "R5 walk");
    chk("R5 sel cleared", sel_dr, 0);
    chk("R5 mode cleared", dev_mode, 0);

    repeat (2) @(negedge tck);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  logic [7:0] i_ops [7] = '{8'h80, 8'h83, 8'h8B, 8'h8E, 8'hFF, 8'h7F, 8'h40};

  initial begin
    #(PER*20000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule